// File: doc/BRIEF.md
# Strobe-Driven DRAM Cycle Decoder with Parallel Test Mode

This block is a synthesizable behavioural model of the control section of an asynchronous-strobe DRAM. A fast sampling clock watches the active-low row strobe, column strobe, write enable and output enable. The block sorts every row-strobe cycle into one of four kinds: ordinary access, column-before-row refresh, row-only refresh, or test-mode entry. Each kind is reported on a small status output. A small flop-based cell array stands in for the storage. Addresses are latched on strobe edges: the row on the row-strobe fall and the column on each column-strobe fall. A single row-strobe period can hold several column pulses.

A latched test mode turns the array into a compressed-test target. While it is set, the two lowest column bits are ignored. Each write stores the data word into all four words of the addressed column group, so 16 cells take data at once. A read returns, per data bit, a flag that is high only when all four cells agree. An 11-bit refresh row counter advances on every plain column-before-row refresh. It is visible for checking.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: After reset, `cyc_kind` is 0 (access), `test_mode` is 0, `rfsh_row` is 0 and `dq_oe` is 0.
- R2: When the row strobe falls while the column strobe is low and write enable is high, `cyc_kind` becomes 1 (column-before-row refresh) one clock later. In that same update `test_mode` clears and `rfsh_row` increments by one.
- R3: `rfsh_row` wraps from 2047 to 0, so it is unchanged after 2048 such refresh cycles.
- R4: When the row strobe falls while both the column strobe and write enable are low, `cyc_kind` becomes 3 and `test_mode` sets one clock later. `rfsh_row` does not change.
- R5: Test mode stays set through access cycles. Any later column-before-row refresh clears it, and so does any row-only refresh.
- R6: A row-strobe-low period that starts with the column strobe high and sees no column-strobe fall is reported as `cyc_kind` = 2 one clock after the row strobe rises. `rfsh_row` does not change.
- R7: In a read, the row comes from `addr` at the row-strobe fall and the column from `addr` at the column-strobe fall. While the column strobe and output enable are both low, `dq_oe` is 1 and `dq_out` shows the stored word. `cyc_kind` reads 0 from the column-strobe fall on.
- R8: If write enable is low at the column-strobe fall, `dq_in` is written there. `dq_oe` stays 0 for that column pulse even with output enable low.
- R9: If write enable falls while a read column pulse is active, `dq_in` is written to the same location and `dq_oe` drops to 0.
- R10: Several column pulses within one row-strobe-low period access different columns of the latched row.
- R11: In test mode, a write ignores column bits 1:0 and stores `dq_in` into all four words of the addressed column group.
- R12: In test mode, a read drives `dq_out[i]` = 1 exactly when bit i is equal in all four words of the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 11 | Multiplexed row/column address |
| dq_in | input | 4 | Write data |
| dq_out | output | 4 | Read data, or per-bit equality flags in test mode |
| dq_oe | output | 1 | Output driver enable |
| cyc_kind | output | 2 | Last cycle kind: 0 access, 1 column-before-row refresh, 2 row-only refresh, 3 test entry |
| test_mode | output | 1 | Latched test-mode flag |
| rfsh_row | output | 11 | Internal refresh row counter |

## Verification
The hardest state to reach is a test-mode read in which the four cells of a group disagree in some bits but not others. Test-mode writes always make a group uniform, so such a pattern cannot be built inside the mode. The stimulus therefore writes four distinct words with ordinary writes first, enters test mode, and reads the group to get a mixed flag word. The counter wrap is reached by a run of 2048 back-to-back refresh cycles.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    typedef enum logic [1:0] {
        CYC_ACCESS = 2'd0,
        CYC_CBR    = 2'd1,
        CYC_RONLY  = 2'd2,
        CYC_TEST   = 2'd3
    } cyc_e;
endpackage

// File: rtl/dcd_edges.sv
module dcd_edges #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= sig;
    end

    assign fall = prev_q & ~sig;
    assign rise = ~prev_q & sig;
endmodule

// File: rtl/dcd_rfsh_ctr.sv
module dcd_rfsh_ctr #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb row_d = inc ? row_q + 1'b1 : row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

    // R3: the counter rolls over from all ones to zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        inc && (row_q == '1) |=> row_q == '0);
    // R6: with no increment the row count holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(row_q));
endmodule

// File: rtl/dcd_cell_array.sv
module dcd_cell_array #(
    parameter int DW  = 4,
    parameter int RAW = 2,
    parameter int CAW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_one,
    input  logic           wr_grp,
    input  logic [RAW-1:0] row,
    input  logic [CAW-1:0] col,
    input  logic [DW-1:0]  din,
    output logic [DW-1:0]  rd_word,
    output logic [DW-1:0]  eq_flag
);
    localparam int WORDS = 1 << (RAW + CAW);
    localparam int GRP   = 4;
    localparam int IW    = RAW + CAW;

    logic [DW-1:0] mem_q [WORDS];
    logic [IW-1:0] idx;

    assign idx = {row, col};

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [IW-1:0] WI = IW'(w);
        logic hit;
        assign hit = (wr_one && idx == WI) ||
                     (wr_grp && idx[IW-1:2] == WI[IW-1:2]);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mem_q[w] <= '0;
            else if (hit) mem_q[w] <= din;
        end
    end

    assign rd_word = mem_q[idx];

    always_comb begin
        logic [DW-1:0] all1, all0;
        all1 = '1;
        all0 = '1;
        for (int k = 0; k < GRP; k++) begin
            all1 &=  mem_q[{idx[IW-1:2], 2'(k)}];
            all0 &= ~mem_q[{idx[IW-1:2], 2'(k)}];
        end
        eq_flag = all1 | all0;
    end
endmodule

// File: rtl/strobe_cycle_decoder.sv
module strobe_cycle_decoder #(
    parameter int ADDR_W = 11,
    parameter int DQ_W   = 4,
    parameter int ARR_RW = 2,
    parameter int ARR_CW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic [1:0]        cyc_kind,
    output logic              test_mode,
    output logic [ADDR_W-1:0] rfsh_row
);
    import dcd_pkg::*;

    typedef struct packed {
        logic              row_open;
        logic              cas_seen;
        logic              cas_act;
        logic              wr_cyc;
        logic              tmode;
        cyc_e              kind;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
    } st_t;

    st_t st_d, st_q;

    logic [2:0] fall, rise;
    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic ctr_inc, wr_one, wr_grp;
    logic [ADDR_W-1:0] wcol;
    logic [DQ_W-1:0] rd_word, eq_flag;

    dcd_edges #(.N(3)) u_edges (
        .clk (clk), .rst_n (rst_n),
        .sig ({we_n, cas_n, ras_n}),
        .fall(fall), .rise(rise)
    );
    assign ras_fall = fall[0];
    assign ras_rise = rise[0];
    assign cas_fall = fall[1];
    assign cas_rise = rise[1];
    assign we_fall  = fall[2];

    always_comb begin
        logic do_wr;
        st_d    = st_q;
        ctr_inc = 1'b0;
        do_wr   = 1'b0;
        wcol    = st_q.col;
        if (ras_fall) begin
            if (!cas_n) begin
                st_d.row_open = 1'b0;
                st_d.tmode    = !we_n;
                st_d.kind     = we_n ? CYC_CBR : CYC_TEST;
                ctr_inc       = we_n;
            end else begin
                st_d.row_open = 1'b1;
                st_d.row      = addr;
                st_d.cas_seen = 1'b0;
                st_d.cas_act  = 1'b0;
                st_d.wr_cyc   = 1'b0;
            end
        end else if (ras_rise) begin
            if (st_q.row_open && !st_q.cas_seen) begin
                st_d.kind  = CYC_RONLY;
                st_d.tmode = 1'b0;
            end
            st_d.row_open = 1'b0;
            st_d.cas_act  = 1'b0;
        end else if (st_q.row_open) begin
            if (cas_fall) begin
                st_d.cas_seen = 1'b1;
                st_d.cas_act  = 1'b1;
                st_d.col      = addr;
                st_d.wr_cyc   = !we_n;
                st_d.kind     = CYC_ACCESS;
                do_wr         = !we_n;
                wcol          = addr;
            end else if (st_q.cas_act && cas_rise) begin
                st_d.cas_act = 1'b0;
            end else if (st_q.cas_act && !st_q.wr_cyc && we_fall) begin
                st_d.wr_cyc = 1'b1;
                do_wr       = 1'b1;
            end
        end
        wr_one = do_wr && !st_q.tmode;
        wr_grp = do_wr && st_q.tmode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= CYC_ACCESS;
        end else begin
            st_q <= st_d;
        end
    end

    dcd_rfsh_ctr #(.ROW_W(ADDR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .inc(ctr_inc), .row(rfsh_row)
    );

    dcd_cell_array #(.DW(DQ_W), .RAW(ARR_RW), .CAW(ARR_CW)) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_one (wr_one),
        .wr_grp (wr_grp),
        .row    (st_q.row[ARR_RW-1:0]),
        .col    (wcol[ARR_CW-1:0]),
        .din    (dq_in),
        .rd_word(rd_word),
        .eq_flag(eq_flag)
    );

    assign dq_oe     = st_q.row_open && st_q.cas_act && !st_q.wr_cyc && !oe_n;
    assign dq_out    = st_q.tmode ? eq_flag : rd_word;
    assign cyc_kind  = st_q.kind;
    assign test_mode = st_q.tmode;

    // R2: refresh with write enable high reports kind 1 and leaves test mode
    a_r2_cbr_kind: assert property (@(posedge clk) disable iff (!rst_n)
        ras_fall && !cas_n && we_n |=> cyc_kind == 2'd1 && !test_mode);
    // R4: refresh with write enable low latches test mode
    a_r4_test_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ras_fall && !cas_n && !we_n |=> test_mode && cyc_kind == 2'd3);
    // R6: an open row closed without a column pulse is a row-only refresh
    a_r6_ronly: assert property (@(posedge clk) disable iff (!rst_n)
        ras_rise && st_q.row_open && !st_q.cas_seen |=> cyc_kind == 2'd2 && !test_mode);
    // R5: test mode only changes on a row-strobe edge
    a_r5_tmode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_fall && !ras_rise |=> $stable(test_mode));
    // R8: an early write never turns the driver on
    a_r8_early_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.row_open && !ras_rise && cas_fall && !we_n |=> !dq_oe);
endmodule

// File: tb/sim_strobe_cycle_decoder.sv
module sim_strobe_cycle_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr = '0;
    logic [3:0] dq_in = '0;
    logic [3:0] dq_out;
    logic dq_oe;
    logic [1:0] cyc_kind;
    logic test_mode;
    logic [10:0] rfsh_row;

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [3:0] ref_mem [32];
    bit tm_exp = 0;
    logic [10:0] exp_ctr = '0;

    always #10 clk = ~clk;

    strobe_cycle_decoder u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .cyc_kind(cyc_kind), .test_mode(test_mode), .rfsh_row(rfsh_row)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ix(input int row, input int col);
        return ((row & 3) << 3) | (col & 7);
    endfunction

    function automatic logic [3:0] flags(input int row, input int col);
        logic [3:0] a1 = 4'hF, a0 = 4'hF;
        for (int k = 0; k < 4; k++) begin
            a1 &=  ref_mem[ix(row, (col & 4) | k)];
            a0 &= ~ref_mem[ix(row, (col & 4) | k)];
        end
        return a1 | a0;
    endfunction

    task automatic close_row();
        cas_n = 1'b1; we_n = 1'b1; tick();
        ras_n = 1'b1; oe_n = 1'b1; tick(); tick();
    endtask

    task automatic t_reset();
        chk(cyc_kind == 2'd0, "R1 kind", cyc_kind, 0);
        chk(test_mode == 1'b0, "R1 tmode", test_mode, 0);
        chk(rfsh_row == 11'd0, "R1 rfsh_row", rfsh_row, 0);
        chk(dq_oe == 1'b0, "R1 dq_oe", dq_oe, 0);
    endtask

    // R8 early write, R11 in test mode
    task automatic t_write(input int row, input int col, input logic [3:0] d);
        ras_n = 1'b0; addr = 11'(row); tick();
        addr = 11'(col); we_n = 1'b0; oe_n = 1'b0; dq_in = d; cas_n = 1'b0; tick();
        chk(dq_oe == 1'b0, "R8 early write keeps dq_oe low", dq_oe, 0);
        if (tm_exp) for (int k = 0; k < 4; k++) ref_mem[ix(row, (col & 4) | k)] = d;
        else ref_mem[ix(row, col)] = d;
        close_row();
    endtask

    // R7 read, R12 in test mode
    task automatic t_read(input int row, input int col, input string tag);
        logic [3:0] e;
        ras_n = 1'b0; addr = 11'(row); tick();
        addr = 11'(col); oe_n = 1'b0; cas_n = 1'b0; tick();
        e = tm_exp ? flags(row, col) : ref_mem[ix(row, col)];
        chk(dq_oe == 1'b1, {tag, " dq_oe"}, dq_oe, 1);
        chk(dq_out == e, {tag, " data"}, dq_out, e);
        chk(cyc_kind == 2'd0, {tag, " kind access"}, cyc_kind, 0);
        close_row();
    endtask

    task automatic t_page(input int row);
        ras_n = 1'b0; addr = 11'(row); tick();
        for (int c = 1; c < 8; c += 3) begin
            addr = 11'(c); oe_n = 1'b0; cas_n = 1'b0; tick();
            chk(dq_out == ref_mem[ix(row, c)], "R10 page read", dq_out, ref_mem[ix(row, c)]);
            cas_n = 1'b1; tick();
            chk(dq_oe == 1'b0, "R10 driver off between pulses", dq_oe, 0);
        end
        close_row();
    endtask

    task automatic t_rmw(input int row, input int col, input logic [3:0] d);
        ras_n = 1'b0; addr = 11'(row); tick();
        addr = 11'(col); oe_n = 1'b0; cas_n = 1'b0; tick();
        chk(dq_out == ref_mem[ix(row, col)], "R9 rmw read part", dq_out, ref_mem[ix(row, col)]);
        dq_in = d; we_n = 1'b0; tick();
        chk(dq_oe == 1'b0, "R9 driver off after write", dq_oe, 0);
        ref_mem[ix(row, col)] = d;
        close_row();
    endtask

    task automatic t_cbr(input bit verbose);
        cas_n = 1'b0; tick();
        ras_n = 1'b0; tick();
        exp_ctr = exp_ctr + 11'd1;
        tm_exp = 0;
        if (verbose) begin
            chk(cyc_kind == 2'd1, "R2 kind cbr", cyc_kind, 1);
            chk(rfsh_row == exp_ctr, "R2 counter step", rfsh_row, exp_ctr);
            chk(test_mode == 1'b0, "R5 cbr clears test mode", test_mode, 0);
        end
        ras_n = 1'b1; tick();
        cas_n = 1'b1; tick();
    endtask

    task automatic t_test_entry();
        cas_n = 1'b0; we_n = 1'b0; tick();
        ras_n = 1'b0; tick();
        tm_exp = 1;
        chk(cyc_kind == 2'd3, "R4 kind test", cyc_kind, 3);
        chk(test_mode == 1'b1, "R4 test mode set", test_mode, 1);
        chk(rfsh_row == exp_ctr, "R4 counter unchanged", rfsh_row, exp_ctr);
        ras_n = 1'b1; tick();
        cas_n = 1'b1; we_n = 1'b1; tick();
    endtask

    task automatic t_ronly(input int row);
        ras_n = 1'b0; addr = 11'(row); tick(); tick();
        ras_n = 1'b1; tick();
        tm_exp = 0;
        chk(cyc_kind == 2'd2, "R6 kind ras-only", cyc_kind, 2);
        chk(test_mode == 1'b0, "R5 ras-only clears test mode", test_mode, 0);
        chk(rfsh_row == exp_ctr, "R6 counter unchanged", rfsh_row, exp_ctr);
        tick();
    endtask

    initial begin
        for (int i = 0; i < 32; i++) ref_mem[i] = '0;
        repeat (3) tick();
        rst_n = 1'b1; tick();
        t_reset();
        t_write(1, 2, 4'hA);
        t_write(3, 7, 4'h5);
        t_read(1, 2, "R7");
        t_read(3, 7, "R7");
        t_write(2, 1, 4'h3);
        t_write(2, 4, 4'hC);
        t_write(2, 7, 4'h9);
        t_page(2);
        t_rmw(1, 2, 4'h6);
        t_read(1, 2, "R9 readback");
        t_cbr(1);
        t_cbr(1);
        // mixed group for the compressed read
        t_write(0, 4, 4'b0011);
        t_write(0, 5, 4'b0101);
        t_write(0, 6, 4'b0001);
        t_write(0, 7, 4'b0111);
        t_test_entry();
        t_read(0, 6, "R12 mixed group");
        chk(test_mode == 1'b1, "R5 test mode held over access", test_mode, 1);
        t_write(1, 1, 4'hB);
        t_read(1, 3, "R12 uniform group");
        t_ronly(5);
        for (int c = 0; c < 4; c++) t_read(1, c, "R11 group copy");
        t_test_entry();
        t_cbr(1);
        for (int n = 0; n < 2048; n++) begin
            t_cbr(0);
            if (exp_ctr == 11'd0) chk(rfsh_row == 11'd0, "R3 wrap to zero", rfsh_row, 0);
        end
        chk(rfsh_row == exp_ctr, "R3 full lap", rfsh_row, exp_ctr);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule